// File: doc/BRIEF.md
# Four-Lane Parallel DDS Phase Generator

This block feeds a phase-to-amplitude stage that sits in front of a converter running at four times the fabric clock. On every fabric clock it presents four consecutive phase words, one for each converter sample in that fabric period. The earliest sample is in the lowest slot. Four accumulators run interleaved. Each one steps by four times the signed tuning word. Each starts one tuning word ahead of the lane below it, so the four lanes together trace one unbroken phase ramp.

The host supplies a signed tuning word and a start-phase offset. Both are captured only when a restart pulse arrives, so all lanes reload together and stay aligned. The cycle after a restart is a priming cycle in which the lanes load their start values and the outputs read zero. While the enable is low, the outputs are zero and the lanes hold their start values. Raising the enable again resumes from sample 0. Each lane also gives a truncated table address, which is the top bits of its phase.

The controller has three states. ST_IDLE holds the lanes at their start values. ST_PRIME loads the start values after a restart. ST_RUN advances the lanes. The transitions are:
- restart, from any state, to ST_PRIME;
- ST_IDLE to ST_RUN when en is high;
- ST_PRIME to ST_RUN when en is high, otherwise to ST_IDLE;
- ST_RUN to ST_IDLE when en is low.

Top module: `quad_phase_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no restart, `phase_bus` and `addr_bus` are zero. The held tuning word and offset are zero.
- R2: Lane k occupies bits [32k+31:32k] of `phase_bus`. Lane 0 holds the earliest sample of the window and lane 3 the latest.
- R3: A restart pulse captures `freq_word` and `phase_ofs`. The cycle after the restart edge shows zero outputs. If en is high, the next cycle shows lane k = ofs + k·fw (mod 2^32).
- R4: Every clock in which the block runs with en high adds 4·fw to every lane, so window m holds samples 4m..4m+3.
- R5: Phase wraps modulo 2^32. A negative tuning word (two's complement) gives a descending phase across lanes and windows.
- R6: A change on `freq_word` or `phase_ofs` without a restart has no effect on the outputs.
- R7: When en is low, all outputs are zero in that same cycle. When en returns high, output resumes at sample 0 of the held settings.
- R8: A restart while en is low still captures the new settings. The outputs stay zero until en rises, and then start at sample 0 of the new settings.
- R9: `addr_bus` slot k (10 bits, at [10k+9:10k]) equals the top 10 bits of lane k's phase, and is zero whenever the phase slot is forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces zero outputs and holds start values |
| restart | input | 1 | One-cycle pulse that captures settings and reloads all lanes |
| freq_word | input | 32 | Signed tuning word, per converter sample |
| phase_ofs | input | 32 | Start-phase offset, same scale as the tuning word |
| phase_bus | output | 128 | Four phase words, lane 0 (earliest) in the low slot |
| addr_bus | output | 40 | Four 10-bit table addresses, lane 0 in the low slot |

## Verification
A lane that loads the wrong start value shows up as a wrong gap between neighbouring slots. This is visible in the first live cycle after a restart or after en rises. A wrong step or a missed advance shows as a window-to-window change other than 4·fw, and it can be seen one clock later. A settings register that follows the inputs instead of the restart shows as soon as the inputs change without a pulse. The bench changes those inputs on random cycles so that such a fault reaches the outputs at once.

// File: rtl/qpg_pkg.sv
package qpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } qpg_state_t;

endpackage

// File: rtl/qpg_lane.sv
module qpg_lane #(
    parameter int PHASE_W  = 32,
    parameter int LANES    = 4,
    parameter int LANE_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic [PHASE_W-1:0] fw,
    input  logic [PHASE_W-1:0] ofs,
    output logic [PHASE_W-1:0] acc
);
    localparam logic [PHASE_W-1:0] K_MUL    = PHASE_W'(LANE_IDX);
    localparam logic [PHASE_W-1:0] STEP_MUL = PHASE_W'(LANES);

    logic [PHASE_W-1:0] preload;
    logic [PHASE_W-1:0] step;

    always_comb begin
        preload = ofs + fw * K_MUL;
        step    = fw * STEP_MUL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= preload;
        end else if (adv) begin
            acc <= acc + step;
        end
    end

endmodule

// File: rtl/qpg_ctrl.sv
module qpg_ctrl
    import qpg_pkg::*;
#(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               restart,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic [PHASE_W-1:0] phase_ofs,
    output logic [PHASE_W-1:0] fw_s,
    output logic [PHASE_W-1:0] ofs_s,
    output logic               lane_load,
    output logic               lane_adv,
    output logic               out_live
);
    qpg_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fw_s  <= '0;
            ofs_s <= '0;
        end else if (restart) begin
            fw_s  <= freq_word;
            ofs_s <= phase_ofs;
        end
    end

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = ST_PRIME;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (en) st_d = ST_RUN;
                ST_PRIME: st_d = en ? ST_RUN : ST_IDLE;
                ST_RUN:   if (!en) st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        lane_load = 1'b0;
        lane_adv  = 1'b0;
        out_live  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                lane_load = !restart;
            end
            ST_PRIME: begin
                lane_load = !restart;
            end
            ST_RUN: begin
                out_live  = en;
                lane_adv  = en && !restart;
                lane_load = !en && !restart;
            end
            default: begin
                lane_load = !restart;
            end
        endcase
    end

endmodule

// File: rtl/qpg_pack.sv
module qpg_pack #(
    parameter int LANES   = 4,
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic                       live,
    input  logic [LANES*PHASE_W-1:0]   lane_flat,
    output logic [LANES*PHASE_W-1:0]   phase_bus,
    output logic [LANES*ADDR_W-1:0]    addr_bus
);
    for (genvar k = 0; k < LANES; k++) begin : g_slot
        logic [PHASE_W-1:0] ph;
        always_comb begin
            ph = live ? lane_flat[k*PHASE_W +: PHASE_W] : '0;
            phase_bus[k*PHASE_W +: PHASE_W] = ph;
            addr_bus[k*ADDR_W +: ADDR_W]    = ph[PHASE_W-1 -: ADDR_W];
        end
    end

endmodule

// File: rtl/quad_phase_gen.sv
module quad_phase_gen
    import qpg_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     restart,
    input  logic [PHASE_W-1:0]       freq_word,
    input  logic [PHASE_W-1:0]       phase_ofs,
    output logic [LANES*PHASE_W-1:0] phase_bus,
    output logic [LANES*ADDR_W-1:0]  addr_bus
);
    localparam int FLAT_W = LANES * PHASE_W;

    logic [PHASE_W-1:0] fw_s;
    logic [PHASE_W-1:0] ofs_s;
    logic               lane_load;
    logic               lane_adv;
    logic               out_live;
    logic [FLAT_W-1:0]  lane_flat;

    qpg_ctrl #(.PHASE_W(PHASE_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .restart   (restart),
        .freq_word (freq_word),
        .phase_ofs (phase_ofs),
        .fw_s      (fw_s),
        .ofs_s     (ofs_s),
        .lane_load (lane_load),
        .lane_adv  (lane_adv),
        .out_live  (out_live)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        qpg_lane #(
            .PHASE_W  (PHASE_W),
            .LANES    (LANES),
            .LANE_IDX (k)
        ) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (lane_load),
            .adv   (lane_adv),
            .fw    (fw_s),
            .ofs   (ofs_s),
            .acc   (lane_flat[k*PHASE_W +: PHASE_W])
        );
    end

    qpg_pack #(
        .LANES   (LANES),
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) pack_i (
        .live      (out_live),
        .lane_flat (lane_flat),
        .phase_bus (phase_bus),
        .addr_bus  (addr_bus)
    );

endmodule

// File: rtl/qpg_chk.sv
module qpg_chk #(
    parameter int LANES   = 4,
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     en,
    input logic                     restart,
    input logic [LANES*PHASE_W-1:0] phase_bus,
    input logic [LANES*ADDR_W-1:0]  addr_bus,
    input logic [PHASE_W-1:0]       fw_s,
    input logic                     out_live
);
    localparam logic [PHASE_W-1:0] STEP_MUL = PHASE_W'(LANES);

    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (phase_bus == '0 && addr_bus == '0)); // R7

    AST_PRIME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> phase_bus == '0); // R3

    AST_WINDOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live && $past(out_live)) |->
        phase_bus[PHASE_W-1:0] == $past(phase_bus[PHASE_W-1:0]) + fw_s * STEP_MUL); // R4

    for (genvar k = 0; k < LANES - 1; k++) begin : g_gap
        AST_LANE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            out_live |->
            phase_bus[(k+1)*PHASE_W +: PHASE_W] - phase_bus[k*PHASE_W +: PHASE_W] == fw_s); // R2
    end

endmodule

bind quad_phase_gen qpg_chk #(
    .LANES   (LANES),
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .restart   (restart),
    .phase_bus (phase_bus),
    .addr_bus  (addr_bus),
    .fw_s      (fw_s),
    .out_live  (out_live)
);

// File: tb/quad_phase_gen_tb.sv
module quad_phase_gen_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         restart = 1'b0;
    logic [31:0]  fw_in = '0;
    logic [31:0]  ofs_in = '0;
    logic [127:0] pb;
    logic [39:0]  ab;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_req = "R1";

    // bench model of the required behaviour
    int          mst = 0;   // 0 idle, 1 prime, 2 run
    logic [31:0] mfw = '0;
    logic [31:0] mofs = '0;
    logic [31:0] mwin = '0;

    always #2 clk = ~clk;

    quad_phase_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .restart   (restart),
        .freq_word (fw_in),
        .phase_ofs (ofs_in),
        .phase_bus (pb),
        .addr_bus  (ab)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mfw = '0; mofs = '0; mwin = '0;
        end else if (restart) begin
            mfw = fw_in; mofs = ofs_in; mst = 1;
        end else begin
            case (mst)
                1: begin mwin = '0; mst = en ? 2 : 0; end
                2: begin
                    if (en) mwin = mwin + 1;
                    else begin mst = 0; mwin = '0; end
                end
                default: begin mwin = '0; if (en) mst = 2; end
            endcase
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] exp_lane(int k);
        return mofs + (mwin * 32'd4 + 32'(k)) * mfw;
    endfunction

    task automatic check_model();
        logic [127:0] ep;
        logic [39:0]  ea;
        bit live;
        live = (mst == 2) && en && rst_n;
        for (int k = 0; k < 4; k++) begin
            ep[k*32 +: 32] = live ? exp_lane(k) : 32'd0;
            ea[k*10 +: 10] = ep[k*32+22 +: 10];
        end
        total++;
        if (pb !== ep || ab !== ea) begin
            bad++;
            $display("FAIL %s model: phase=%h addr=%h expected phase=%h addr=%h",
                     cur_req, pb, ab, ep, ea);
        end
    endtask

    task automatic check_bus(string req, logic [127:0] exp);
        total++;
        if (pb !== exp) begin
            bad++;
            $display("FAIL %s phase=%h expected %h", req, pb, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_model();
    endtask

    initial begin
        repeat (3) tick();
        check_bus("R1", 128'd0);
        rst_n = 1'b1;
        tick();
        total++;
        if (ab !== 40'd0) begin bad++; $display("FAIL R1 addr=%h expected 0", ab); end

        // R2 / R3: unit step, zero offset
        cur_req = "R3";
        fw_in = 32'd1; ofs_in = 32'd0; en = 1'b1; restart = 1'b1;
        tick();
        check_bus("R3", 128'd0);
        restart = 1'b0;
        tick();
        check_bus("R2", {32'd3, 32'd2, 32'd1, 32'd0});
        cur_req = "R4";
        tick();
        check_bus("R4", {32'd7, 32'd6, 32'd5, 32'd4});

        // R6: new settings without restart
        cur_req = "R6";
        fw_in = 32'd100; ofs_in = 32'd5;
        tick();
        check_bus("R6", {32'd11, 32'd10, 32'd9, 32'd8});

        // R7: enable low then high resumes at sample 0
        cur_req = "R7";
        en = 1'b0;
        tick();
        check_bus("R7", 128'd0);
        en = 1'b1;
        tick();
        check_bus("R7", {32'd3, 32'd2, 32'd1, 32'd0});

        // R5: negative tuning word
        cur_req = "R5";
        fw_in = 32'hFFFF_FFFF; ofs_in = 32'd0; restart = 1'b1;
        tick();
        restart = 1'b0;
        tick();
        check_bus("R5", {32'hFFFF_FFFD, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'd0});
        tick();
        check_bus("R5", {32'hFFFF_FFF9, 32'hFFFF_FFFA, 32'hFFFF_FFFB, 32'hFFFF_FFFC});

        // R5 / R9: wrap with large step, addresses
        fw_in = 32'h4000_0000; ofs_in = 32'hC000_0000; restart = 1'b1;
        tick();
        restart = 1'b0;
        tick();
        check_bus("R5", {32'h8000_0000, 32'h4000_0000, 32'd0, 32'hC000_0000});
        total++;
        if (ab !== {10'h200, 10'h100, 10'h000, 10'h300}) begin
            bad++;
            $display("FAIL R9 addr=%h expected %h", ab, {10'h200, 10'h100, 10'h000, 10'h300});
        end

        // R8: restart while disabled
        cur_req = "R8";
        en = 1'b0; fw_in = 32'd3; ofs_in = 32'd10; restart = 1'b1;
        tick();
        restart = 1'b0;
        check_bus("R8", 128'd0);
        tick();
        check_bus("R8", 128'd0);
        en = 1'b1;
        tick();
        check_bus("R8", {32'd19, 32'd16, 32'd13, 32'd10});

        // random phase
        cur_req = "R4";
        void'($urandom(32'd1234));
        for (int i = 0; i < 2000; i++) begin
            fw_in   = $urandom();
            ofs_in  = $urandom();
            restart = ($urandom_range(15) == 0);
            en      = ($urandom_range(9) != 0);
            tick();
        end
        restart = 1'b0;
        en = 1'b1;
        repeat (4) tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule